// File: doc/BRIEF.md
# Banked Host Register File with Rotating Identification Counter

This block is the byte-wide register front end of a network controller as seen by a host. Sixteen offsets are visible at a time, and one of three register banks decides what lies behind most of them. The host picks the bank by writing a byte to offset 0. The two high bits of that byte carry the bank number. A dedicated command code written to offset 0 forces bank 0 back. Offset 0 reads back the current bank in its two high bits, whatever bank is active.

Bank 0 holds the interrupt status register, an interrupt mask and an identification register. Status bits are set by internal event pulses and cleared by the host writing ones. The identification register returns a fixed signature pattern. Its top two bits form a counter that steps on every read of that register. A probe routine can read it twice and see the change, which separates a live device from plain memory or a floating bus. Bank 1 holds the receive and transmit buffer limit pages. Bank 2 holds three configuration bytes and the six-byte station address. The limits and the address are also driven onto output ports for the rest of the controller.

Read data is registered. It appears with a valid pulse one clock after the read strobe and then holds until the next read.

Top module: `bank_reg_file`

## Requirements
- R1: A write to offset 0 sets the active bank to bits 7:6 of the written byte (0x00 gives bank 0, 0x40 bank 1, 0x80 bank 2). A byte with bits 7:6 equal to 3 leaves the bank unchanged. A read of offset 0 in any bank returns the bank number in bits 7:6 and zero below.
- R2: Writing the reset command code 0x0E to offset 0 returns the block to bank 0.
- R3: The active bank changes only on writes to offset 0. Writes to every other offset leave it unchanged.
- R4: A read of bank 0 offset 2 returns the identification byte. Bits 5 and 2 are one and bit 3 is zero, so the bits under mask 0x2C read 0x24. Bit 4 equals the AUTO_EN parameter (default 1), and bits 1:0 are zero.
- R5: Bits 7:6 of the identification byte are a counter that is 0 after reset. Each read returns the current value, and the counter then advances by one, wrapping from 3 to 0.
- R6: The identification counter does not change on writes to any offset, including bank 0 offset 2, or on reads of any other offset or bank. The identification register is read-only.
- R7: Bank 0 offset 1 is the status register. Every bit written as one is cleared, so writing 0x0F clears the low four bits together and writing zeros has no effect.
- R8: Each bit of statusSet sets the matching status bit. When a set and a host clear hit the same bit in the same cycle, the bit ends up set.
- R9: In bank 2, offsets 4 through 9 hold station address bytes 0 through 5 in that order. Byte k appears on stationAddr[47-8k:40-8k], and the bytes read back as written.
- R10: Bank 1 offsets 8 and 9 hold the receive lower and upper limit pages and drive rxLowerPage and rxUpperPage. Bank 1 offsets 10 and 11, bank 0 offset 3 and bank 2 offsets 1 to 3 are plain read/write bytes.
- R11: Reads of any offset not named in R1, R4, R7, R9 or R10 for the active bank return zero, and writes to such offsets have no effect.
- R12: rdValid is high exactly in the cycle after a cycle with rdEn. rdata then holds the value read and keeps it until the next read. After reset the bank is 0, all registers are zero, rdata is 0 and rdValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| offs | input | 4 | Register offset within the active bank |
| wdata | input | 8 | Host write byte |
| statusSet | input | 8 | Event pulses that set status bits |
| rdata | output | 8 | Registered read byte |
| rdValid | output | 1 | High one cycle after a read |
| curBank | output | 2 | Active bank number |
| stationAddr | output | 48 | Station address, byte 0 in the top bits |
| rxLowerPage | output | 8 | Receive lower limit page |
| rxUpperPage | output | 8 | Receive upper limit page |

## Verification
Two pairs of functions can land on the same edge here. The first is an event set and a host write-one-to-clear on the same status bit. The second is a read and a write in the same cycle, for example an offset 0 write that moves the bank while a read decodes its offset. Directed steps drive both pairs on one clock: a statusSet pulse together with a clearing write, and a bank switch together with a read of offset 0. The following clock then has to show the set bit and the pre-write bank. A long random run then mixes reads, writes and event pulses across all offsets and banks. Each clock is judged against a behavioural model that updates in the order read, then write, then event set.

// File: rtl/bank_reg_pkg.sv
package bank_reg_pkg;
  localparam int DATA_W    = 8;
  localparam int OFFS_W    = 4;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int SA_BYTES  = 6;
  localparam int ID_CNT_W  = 2;

  localparam logic [DATA_W-1:0] RESET_CODE   = 8'h0E;
  localparam logic [DATA_W-1:0] ID_SIGNATURE = 8'h24;
  localparam logic [DATA_W-1:0] ID_AUTO_BIT  = 8'h10;

  typedef enum logic [4:0] {
    SL_NONE, SL_CMD, SL_STATUS, SL_ID, SL_IMASK,
    SL_RXLO, SL_RXHI, SL_TXLO, SL_TXHI,
    SL_CFG1, SL_CFG2, SL_CFG3,
    SL_SA0, SL_SA1, SL_SA2, SL_SA3, SL_SA4, SL_SA5
  } slot_e;

  typedef struct packed {
    logic  wrHit;
    slot_e wrSlot;
    logic  rdHit;
    slot_e rdSlot;
  } strobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_reg_pkg::*;
#(
  parameter int NBANK = NUM_BANKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [OFFS_W-1:0] offs,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           strb,
  output logic [BANK_W-1:0] bankQ
);
  localparam int SEL_LSB = DATA_W - BANK_W;

  function automatic slot_e decodeSlot(input logic [BANK_W-1:0] b,
                                       input logic [OFFS_W-1:0] o);
    slot_e s;
    s = SL_NONE;
    if (o == '0) begin
      s = SL_CMD;
    end else begin
      case (b)
        2'd0: case (o)
          4'd1: s = SL_STATUS;
          4'd2: s = SL_ID;
          4'd3: s = SL_IMASK;
          default: s = SL_NONE;
        endcase
        2'd1: case (o)
          4'd8:  s = SL_RXLO;
          4'd9:  s = SL_RXHI;
          4'd10: s = SL_TXLO;
          4'd11: s = SL_TXHI;
          default: s = SL_NONE;
        endcase
        2'd2: case (o)
          4'd1: s = SL_CFG1;
          4'd2: s = SL_CFG2;
          4'd3: s = SL_CFG3;
          4'd4: s = SL_SA0;
          4'd5: s = SL_SA1;
          4'd6: s = SL_SA2;
          4'd7: s = SL_SA3;
          4'd8: s = SL_SA4;
          4'd9: s = SL_SA5;
          default: s = SL_NONE;
        endcase
        default: s = SL_NONE;
      endcase
    end
    return s;
  endfunction

  slot_e curSlot;
  logic [BANK_W-1:0] reqBank;
  logic bankWrite;

  always_comb begin
    curSlot = decodeSlot(bankQ, offs);
    strb.wrSlot = curSlot;
    strb.rdSlot = curSlot;
    strb.wrHit  = wrEn && (curSlot != SL_NONE) && (curSlot != SL_CMD);
    strb.rdHit  = rdEn;
  end

  assign reqBank   = wdata[DATA_W-1:SEL_LSB];
  assign bankWrite = wrEn && (curSlot == SL_CMD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= '0;
    end else if (bankWrite) begin
      if (wdata == RESET_CODE)
        bankQ <= '0;
      else if (int'(reqBank) < NBANK)
        bankQ <= reqBank;
    end
  end
endmodule

// File: rtl/id_counter.sv
module id_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (advance)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bank_reg_pkg::*;
#(
  parameter bit AUTO_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [DATA_W-1:0]      statusSet,
  input  logic [BANK_W-1:0]      bank,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rdValid,
  output logic [SA_BYTES*DATA_W-1:0] stationAddr,
  output logic [DATA_W-1:0]      rxLowerPage,
  output logic [DATA_W-1:0]      rxUpperPage
);
  localparam logic [4:0] SA_BASE = SL_SA0;
  localparam logic [4:0] SA_LAST = SL_SA5;
  localparam int SA_IDX_W = $clog2(SA_BYTES);

  logic [DATA_W-1:0] statusQ, imaskQ, txLoQ, txHiQ, rxLoQ, rxHiQ;
  logic [DATA_W-1:0] cfgQ [3];
  logic [DATA_W-1:0] saQ [SA_BYTES];
  logic [ID_CNT_W-1:0] idCount;
  logic [DATA_W-1:0] idByte, readMux, clrMask;
  logic [4:0] saIdx;
  logic idAdvance;

  function automatic logic wrTo(input strobe_t s, input slot_e t);
    return s.wrHit && (s.wrSlot == t);
  endfunction

  assign idAdvance = strb.rdHit && (strb.rdSlot == SL_ID);

  id_counter #(.CNT_W(ID_CNT_W)) u_idCnt (
    .clk     (clk),
    .rstN    (rstN),
    .advance (idAdvance),
    .count   (idCount)
  );

  assign idByte = {idCount, {(DATA_W-ID_CNT_W){1'b0}}} | ID_SIGNATURE
                | (AUTO_EN ? ID_AUTO_BIT : '0);

  assign clrMask = wrTo(strb, SL_STATUS) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | statusSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imaskQ <= '0; txLoQ <= '0; txHiQ <= '0; rxLoQ <= '0; rxHiQ <= '0;
    end else begin
      if (wrTo(strb, SL_IMASK)) imaskQ <= wdata;
      if (wrTo(strb, SL_TXLO))  txLoQ  <= wdata;
      if (wrTo(strb, SL_TXHI))  txHiQ  <= wdata;
      if (wrTo(strb, SL_RXLO))  rxLoQ  <= wdata;
      if (wrTo(strb, SL_RXHI))  rxHiQ  <= wdata;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_cfg
    localparam logic [4:0] MY_SLOT = 5'(SL_CFG1) + 5'(c);
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgQ[c] <= '0;
      else if (strb.wrHit && (5'(strb.wrSlot) == MY_SLOT))
        cfgQ[c] <= wdata;
    end
  end

  for (genvar k = 0; k < SA_BYTES; k++) begin : g_sa
    localparam logic [4:0] MY_SLOT = SA_BASE + 5'(k);
    always_ff @(posedge clk) begin
      if (!rstN)
        saQ[k] <= '0;
      else if (strb.wrHit && (5'(strb.wrSlot) == MY_SLOT))
        saQ[k] <= wdata;
    end
    assign stationAddr[(SA_BYTES-k)*DATA_W-1 -: DATA_W] = saQ[k];
  end

  assign saIdx = 5'(strb.rdSlot) - SA_BASE;

  always_comb begin
    readMux = '0;
    case (strb.rdSlot)
      SL_CMD:    readMux = {bank, {(DATA_W-BANK_W){1'b0}}};
      SL_STATUS: readMux = statusQ;
      SL_ID:     readMux = idByte;
      SL_IMASK:  readMux = imaskQ;
      SL_RXLO:   readMux = rxLoQ;
      SL_RXHI:   readMux = rxHiQ;
      SL_TXLO:   readMux = txLoQ;
      SL_TXHI:   readMux = txHiQ;
      SL_CFG1:   readMux = cfgQ[0];
      SL_CFG2:   readMux = cfgQ[1];
      SL_CFG3:   readMux = cfgQ[2];
      default: begin
        if (5'(strb.rdSlot) >= SA_BASE && 5'(strb.rdSlot) <= SA_LAST)
          readMux = saQ[saIdx[SA_IDX_W-1:0]];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdHit;
      if (strb.rdHit) rdata <= readMux;
    end
  end

  assign rxLowerPage = rxLoQ;
  assign rxUpperPage = rxHiQ;
endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
  import bank_reg_pkg::*;
#(
  parameter bit AUTO_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  offs,
  input  logic [7:0]  wdata,
  input  logic [7:0]  statusSet,
  output logic [7:0]  rdata,
  output logic        rdValid,
  output logic [1:0]  curBank,
  output logic [47:0] stationAddr,
  output logic [7:0]  rxLowerPage,
  output logic [7:0]  rxUpperPage
);
  strobe_t strb;

  bank_ctrl #(.NBANK(NUM_BANKS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .offs  (offs),
    .wdata (wdata),
    .strb  (strb),
    .bankQ (curBank)
  );

  bank_datapath #(.AUTO_EN(AUTO_EN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wdata       (wdata),
    .statusSet   (statusSet),
    .bank        (curBank),
    .rdata       (rdata),
    .rdValid     (rdValid),
    .stationAddr (stationAddr),
    .rxLowerPage (rxLowerPage),
    .rxUpperPage (rxUpperPage)
  );
endmodule

// File: rtl/bank_reg_chk.sv
module bank_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic [3:0]  offs,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        rdValid,
  input logic [1:0]  curBank,
  input logic [47:0] stationAddr
);
  logic idReadD, haveId;
  logic [1:0] lastCnt;
  logic idResult;

  assign idResult = rdValid && idReadD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReadD <= 1'b0;
      haveId  <= 1'b0;
      lastCnt <= 2'd0;
    end else begin
      idReadD <= rdEn && (offs == 4'd2) && (curBank == 2'd0);
      if (idResult) begin
        haveId  <= 1'b1;
        lastCnt <= rdata[7:6];
      end
    end
  end

  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    curBank != 2'd3); // R1

  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && offs == 4'd0 && wdata == 8'h0E) |=> (curBank == 2'd0)); // R2

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && offs != 4'd0) |=> $stable(curBank)); // R3

  AST_ID_SIG: assert property (@(posedge clk) disable iff (!rstN)
    idResult |-> ((rdata & 8'h2C) == 8'h24)); // R4

  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (idResult && haveId) |-> (rdata[7:6] == lastCnt + 2'd1)); // R5

  AST_SA_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && curBank == 2'd2 && offs == 4'd4) |=> (stationAddr[47:40] == $past(wdata))); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && curBank == 2'd0 && offs == 4'd5) |=> (rdata == 8'h00)); // R11

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R12

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (!rdValid && $stable(rdata))); // R12
endmodule

bind bank_reg_file bank_reg_chk u_chk (.*);

// File: tb/sim_bank_reg_file.sv
module sim_bank_reg_file;
  localparam int CLK_PERIOD = 10;
  localparam bit AUTO = 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] offs = '0;
  logic [7:0] wdata = '0, statusSet = '0;
  logic [7:0] rdata;
  logic rdValid;
  logic [1:0] curBank;
  logic [47:0] stationAddr;
  logic [7:0] rxLowerPage, rxUpperPage;

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;

  // behavioural model
  int mBank = 0;
  int mCnt = 0;
  logic [7:0] mStat = '0;
  logic [7:0] mReg [3][16];
  logic [7:0] mLastR = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_reg_file #(.AUTO_EN(AUTO)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .offs(offs),
    .wdata(wdata), .statusSet(statusSet), .rdata(rdata), .rdValid(rdValid),
    .curBank(curBank), .stationAddr(stationAddr),
    .rxLowerPage(rxLowerPage), .rxUpperPage(rxUpperPage)
  );

  function automatic bit writable(int b, int o);
    if (b == 0) return o == 3;
    if (b == 1) return o >= 8 && o <= 11;
    if (b == 2) return o >= 1 && o <= 9;
    return 1'b0;
  endfunction

  function automatic logic [7:0] mRead(int o);
    if (o == 0) return 8'(mBank << 6);
    if (mBank == 0 && o == 1) return mStat;
    if (mBank == 0 && o == 2) return 8'(mCnt << 6) | 8'h24 | (AUTO ? 8'h10 : 8'h00);
    if (writable(mBank, o)) return mReg[mBank][o];
    return 8'h00;
  endfunction

  function automatic void mWrite(int o, logic [7:0] d);
    if (o == 0) begin
      if (d == 8'h0E) mBank = 0;
      else if (d[7:6] != 2'd3) mBank = int'(d[7:6]);
    end else if (mBank == 0 && o == 1) begin
      mStat = mStat & ~d;
    end else if (writable(mBank, o)) begin
      mReg[mBank][o] = d;
    end
  endfunction

  task automatic check(input string tag, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input int o, input logic [7:0] d,
                      input logic [7:0] s, input string tag);
    logic [7:0] expR;
    logic [47:0] expSa;
    @(negedge clk);
    wrEn = w; rdEn = r; offs = 4'(o); wdata = d; statusSet = s;
    expR = mRead(o);
    if (r) mLastR = expR;
    if (r && mBank == 0 && o == 2) mCnt = (mCnt + 1) % 4;
    if (w) mWrite(o, d);
    mStat = mStat | s;
    @(posedge clk);
    #1;
    wrEn = 0; rdEn = 0; statusSet = '0;
    expSa = {mReg[2][4], mReg[2][5], mReg[2][6], mReg[2][7], mReg[2][8], mReg[2][9]};
    check(tag, (rdValid == r) && (rdata == mLastR) && (curBank == 2'(mBank))
               && (stationAddr == expSa) && (rxLowerPage == mReg[1][8])
               && (rxUpperPage == mReg[1][9]),
          {rdValid, 7'd0, rdata, 6'd0, curBank, stationAddr[39:0]},
          {r, 7'd0, mLastR, 6'd0, 2'(mBank), expSa[39:0]});
  endtask

  task automatic rd(input int o, input string tag);
    step(1'b0, 1'b1, o, 8'h00, 8'h00, tag);
  endtask

  task automatic wr(input int o, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, o, d, 8'h00, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 3; b++)
      for (int o = 0; o < 16; o++) mReg[b][o] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // reset state, R12
    check("R12 reset", (rdata == 0) && !rdValid && (curBank == 0) && (stationAddr == 0)
          && (rxLowerPage == 0) && (rxUpperPage == 0),
          {rdata, 6'd0, curBank, 1'b0, rdValid}, 64'd0);

    // R4 R5: identification signature and counter wrap
    for (int i = 0; i < 5; i++) rd(2, "R5 id counter step");
    rd(2, "R4 id signature");

    // R6: other reads and writes leave counter alone; R11 unimplemented offset
    rd(1, "R6 read status no advance");
    rd(3, "R6 read mask no advance");
    rd(5, "R11 bank0 offset5 zero");
    wr(2, 8'hFF, "R6 write id ignored");
    rd(2, "R6 id after other accesses");

    // R1 bank select and read back
    wr(0, 8'h40, "R1 select bank1");
    rd(0, "R1 offset0 reads bank");
    wr(8, 8'h12, "R10 rx lower");
    wr(9, 8'h5F, "R10 rx upper");
    wr(10, 8'h60, "R10 tx lower");
    rd(8, "R10 rx lower readback");
    rd(10, "R10 tx lower readback");
    rd(2, "R6 bank1 offset2 is not id");
    wr(3, 8'hAA, "R3 write other offset keeps bank");
    rd(3, "R11 bank1 offset3 zero");
    wr(0, 8'hC0, "R1 bank3 ignored");
    wr(0, 8'h80, "R1 select bank2");
    for (int k = 0; k < 6; k++) wr(4 + k, 8'(8'hA0 + k), "R9 station byte");
    for (int k = 0; k < 6; k++) rd(4 + k, "R9 station readback");
    wr(1, 8'h33, "R10 cfg write");
    rd(1, "R10 cfg readback");
    rd(15, "R11 bank2 offset15 zero");
    wr(0, 8'h0E, "R2 reset command");
    rd(2, "R6 id kept over bank travel");

    // R7 R8 status
    step(1'b0, 1'b0, 0, 8'h00, 8'hFF, "R8 event set");
    rd(1, "R8 status after set");
    wr(1, 8'h0F, "R7 clear low four");
    rd(1, "R7 status after clear");
    wr(1, 8'h00, "R7 zero write no effect");
    rd(1, "R7 status unchanged");
    step(1'b1, 1'b0, 1, 8'hC0, 8'h40, "R8 set beats clear");
    rd(1, "R8 status after collision");

    // read and bank switch in the same cycle: read uses old bank
    step(1'b1, 1'b1, 0, 8'h40, 8'h00, "R1 read with bank write");
    rd(0, "R1 new bank visible");
    wr(0, 8'h00, "R1 back to bank0");

    // random mixed traffic, R12 and all others
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom), 1'($urandom), int'($urandom % 16),
           8'($urandom), (($urandom % 4) == 0) ? 8'($urandom) : 8'h00,
           "R12 random traffic");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule